// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block handles even parity for two multiplexed 32-bit address/data buses, a host side and a card side. Each bus carries a 4-bit command/byte-enable field beside the address/data lines. Whenever a side drives the bus, the block produces the matching parity bit one clock later, together with its output enable. Whenever a side receives, the block computes the parity it expects and compares it with the parity bit that arrives one clock after the phase.

A data-phase mismatch on a side pulls that side's active-low parity-error output low for one clock. The pulse starts two clocks after the data phase. An address-phase mismatch on either side becomes a one-clock, active-low system-error pulse on the host side. Two enable inputs gate the reports: a parity-response enable and a system-error enable. Data phases that belong to a special-cycle command are never reported.

Two sticky status bits record what happened: one for any detected parity error and one for any system error that was signalled. Each bit is cleared by pulsing its clear input.

Top module: `bus_parity_unit`

## Requirements
- R1: A driven phase produces a parity bit equal to the XOR of all 32 address/data bits and all 4 command/byte-enable bits. The 37 bits together then hold an even number of ones. The bit appears on the side's parity output in the clock after the phase.
- R2: A side's parity output enable is high in exactly the clocks that follow a clock in which that side's drive input was high.
- R3: A receiving side (drive low) records a data phase on a rising edge where both ready inputs are high. If the parity bit sampled on the next edge differs from the computed parity, that side's parity-error output goes low for exactly one clock, starting on the second edge after the data phase.
- R4: A data phase with only one of the two ready inputs high is not checked, and bad parity in it produces no parity-error pulse.
- R5: With the parity-response enable low, no parity-error or system-error pulse is produced.
- R6: An address phase whose command field is 4'b0001 (special cycle) marks the data phases that follow on that side as exempt from parity-error reporting. The mark lasts until the next address phase on that side.
- R7: A host-side address phase with bad parity gives a one-clock low pulse on the system-error output, two edges after the address phase. This happens only when both the parity-response enable and the system-error enable are high. The device does not need to be the target of the cycle.
- R8: A card-side address parity error produces the same host-side system-error pulse. A card-side data parity error drives the card-side parity-error output.
- R9: The detected-parity status bit is set by any address or data parity mismatch, whatever the enables are. The signalled-system-error status bit is set whenever a system-error pulse is issued. `stat_clr[0]` clears the first bit and `stat_clr[1]` clears the second. A new event wins over a clear in the same clock.
- R10: During and right after reset, both parity-error outputs and the system-error output are high, both parity output enables are low, and both status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| perr_resp_en | input | 1 | Parity-response enable |
| serr_en | input | 1 | System-error enable |
| stat_clr | input | 2 | Clear pulses: bit 0 detected-parity, bit 1 signalled-system-error |
| h_ad | input | 32 | Host address/data |
| h_cbe | input | 4 | Host command/byte enables |
| h_par_i | input | 1 | Host received parity bit |
| h_addr_vld | input | 1 | Host address phase this clock |
| h_irdy | input | 1 | Host initiator ready |
| h_trdy | input | 1 | Host target ready |
| h_drive | input | 1 | Host side driven by this device this clock |
| h_par_o | output | 1 | Host generated parity |
| h_par_oe | output | 1 | Host parity output enable |
| h_perr_n | output | 1 | Host data parity error, active low |
| h_serr_n | output | 1 | Host system-error pulse, active low |
| c_ad | input | 32 | Card address/data |
| c_cbe | input | 4 | Card command/byte enables |
| c_par_i | input | 1 | Card received parity bit |
| c_addr_vld | input | 1 | Card address phase this clock |
| c_irdy | input | 1 | Card initiator ready |
| c_trdy | input | 1 | Card target ready |
| c_drive | input | 1 | Card side driven by this device this clock |
| c_par_o | output | 1 | Card generated parity |
| c_par_oe | output | 1 | Card parity output enable |
| c_perr_n | output | 1 | Card data parity error, active low |
| stat_parity_err | output | 1 | Sticky detected-parity status |
| stat_sys_err | output | 1 | Sticky signalled-system-error status |

## Verification
The bench goes after the cycle of the error pulse. A design that compared parity against the same phase's bit, or reported one edge early, would pulse a clock too soon or miss mismatches. It also goes after half-handshake phases: a checker that ignored one ready signal would report errors on phases that never completed. Special-cycle exemption is tested in both directions, so that a design which never clears the exemption, or never sets it, would stay silent or fire falsely. The enable combinations and the card-to-host system-error forwarding are tested too, because a design with a missing gate would pulse when disabled.

// File: rtl/bpar_pkg.sv
package bpar_pkg;
    localparam int AD_W  = 32;
    localparam int CBE_W = 4;
    localparam int NSIDE = 2;
    localparam logic [CBE_W-1:0] CMD_SPECIAL = 4'b0001;

    typedef struct packed {
        logic [AD_W-1:0]  ad;
        logic [CBE_W-1:0] cbe;
    } phase_t;

    typedef struct packed {
        logic data_err;
        logic addr_err;
    } chk_res_t;

    function automatic logic even_par(input phase_t ph);
        return ^{ph.ad, ph.cbe};
    endfunction
endpackage

// File: rtl/bpar_gen.sv
module bpar_gen
    import bpar_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t ph,
    input  logic   drive,
    output logic   par_o,
    output logic   par_oe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            par_o  <= 1'b0;
            par_oe <= 1'b0;
        end else begin
            par_o  <= even_par(ph);
            par_oe <= drive;
        end
    end

    // R2: enable follows drive by one clock
    p_oe_follows_drive_r2: assert property (@(posedge clk) disable iff (rst)
        drive |=> par_oe);

    // R1: parity output makes the previous phase even
    p_par_even_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(drive)) |-> ((^{$past(ph.ad), $past(ph.cbe), par_o}) == 1'b0));
endmodule

// File: rtl/bpar_chk.sv
module bpar_chk
    import bpar_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  phase_t   ph,
    input  logic     par_i,
    input  logic     addr_vld,
    input  logic     irdy,
    input  logic     trdy,
    input  logic     drive,
    output chk_res_t res
);
    logic special_q;
    logic exp_q;
    logic dchk_q;
    logic achk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            special_q <= 1'b0;
            exp_q     <= 1'b0;
            dchk_q    <= 1'b0;
            achk_q    <= 1'b0;
            res       <= '0;
        end else begin
            if (addr_vld)
                special_q <= (ph.cbe == CMD_SPECIAL);
            exp_q        <= even_par(ph);
            dchk_q       <= irdy && trdy && !drive && !addr_vld && !special_q;
            achk_q       <= addr_vld && !drive;
            res.data_err <= dchk_q && (exp_q != par_i);
            res.addr_err <= achk_q && (exp_q != par_i);
        end
    end

    // R4: a reported data error needs a full handshake two edges back
    p_full_handshake_r4: assert property (@(posedge clk) disable iff (rst)
        res.data_err |-> $past(irdy && trdy, 2));

    // R6: no data error from a phase inside a special cycle
    p_no_special_report_r6: assert property (@(posedge clk) disable iff (rst)
        res.data_err |-> !$past(special_q, 2));
endmodule

// File: rtl/bpar_report.sv
module bpar_report
    import bpar_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   perr_resp_en,
    input  logic                   serr_en,
    input  logic [1:0]             stat_clr,
    input  chk_res_t [NSIDE-1:0]   res,
    output logic [NSIDE-1:0]       perr_n,
    output logic                   serr_n,
    output logic                   stat_pe,
    output logic                   stat_se
);
    logic any_addr;
    logic any_err;
    logic serr_fire;

    always_comb begin
        any_addr = 1'b0;
        any_err  = 1'b0;
        for (int i = 0; i < NSIDE; i++) begin
            any_addr = any_addr | res[i].addr_err;
            any_err  = any_err | res[i].addr_err | res[i].data_err;
        end
        serr_fire = any_addr && perr_resp_en && serr_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            perr_n  <= '1;
            serr_n  <= 1'b1;
            stat_pe <= 1'b0;
            stat_se <= 1'b0;
        end else begin
            for (int i = 0; i < NSIDE; i++)
                perr_n[i] <= !(res[i].data_err && perr_resp_en);
            serr_n  <= !serr_fire;
            stat_pe <= (stat_pe && !stat_clr[0]) || any_err;
            stat_se <= (stat_se && !stat_clr[1]) || serr_fire;
        end
    end

    // R5: a host parity-error pulse needs the response enable
    p_perr_gated_r5: assert property (@(posedge clk) disable iff (rst)
        !perr_n[0] |-> $past(perr_resp_en));

    // R7: a system-error pulse needs both enables
    p_serr_gated_r7: assert property (@(posedge clk) disable iff (rst)
        !serr_n |-> ($past(perr_resp_en) && $past(serr_en)));

    // R9: status holds until cleared
    p_status_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (stat_pe && !stat_clr[0]) |=> stat_pe);

    // R9: a signalled system error is always also a detected parity error
    p_se_implies_pe_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_se) |-> stat_pe);
endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit
    import bpar_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        perr_resp_en,
    input  logic        serr_en,
    input  logic [1:0]  stat_clr,
    input  logic [31:0] h_ad,
    input  logic [3:0]  h_cbe,
    input  logic        h_par_i,
    input  logic        h_addr_vld,
    input  logic        h_irdy,
    input  logic        h_trdy,
    input  logic        h_drive,
    output logic        h_par_o,
    output logic        h_par_oe,
    output logic        h_perr_n,
    output logic        h_serr_n,
    input  logic [31:0] c_ad,
    input  logic [3:0]  c_cbe,
    input  logic        c_par_i,
    input  logic        c_addr_vld,
    input  logic        c_irdy,
    input  logic        c_trdy,
    input  logic        c_drive,
    output logic        c_par_o,
    output logic        c_par_oe,
    output logic        c_perr_n,
    output logic        stat_parity_err,
    output logic        stat_sys_err
);
    phase_t               ph_a  [NSIDE];
    logic [NSIDE-1:0]     par_i_a, avld_a, irdy_a, trdy_a, drv_a;
    logic [NSIDE-1:0]     par_o_a, par_oe_a, perr_n_a;
    chk_res_t [NSIDE-1:0] res_a;

    assign ph_a[0]  = {h_ad, h_cbe};
    assign ph_a[1]  = {c_ad, c_cbe};
    assign par_i_a  = {c_par_i, h_par_i};
    assign avld_a   = {c_addr_vld, h_addr_vld};
    assign irdy_a   = {c_irdy, h_irdy};
    assign trdy_a   = {c_trdy, h_trdy};
    assign drv_a    = {c_drive, h_drive};

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        bpar_gen u_gen (
            .clk    (clk),
            .rst    (rst),
            .ph     (ph_a[s]),
            .drive  (drv_a[s]),
            .par_o  (par_o_a[s]),
            .par_oe (par_oe_a[s])
        );
        bpar_chk u_chk (
            .clk      (clk),
            .rst      (rst),
            .ph       (ph_a[s]),
            .par_i    (par_i_a[s]),
            .addr_vld (avld_a[s]),
            .irdy     (irdy_a[s]),
            .trdy     (trdy_a[s]),
            .drive    (drv_a[s]),
            .res      (res_a[s])
        );
    end

    bpar_report u_report (
        .clk          (clk),
        .rst          (rst),
        .perr_resp_en (perr_resp_en),
        .serr_en      (serr_en),
        .stat_clr     (stat_clr),
        .res          (res_a),
        .perr_n       (perr_n_a),
        .serr_n       (h_serr_n),
        .stat_pe      (stat_parity_err),
        .stat_se      (stat_sys_err)
    );

    assign h_par_o  = par_o_a[0];
    assign c_par_o  = par_o_a[1];
    assign h_par_oe = par_oe_a[0];
    assign c_par_oe = par_oe_a[1];
    assign h_perr_n = perr_n_a[0];
    assign c_perr_n = perr_n_a[1];
endmodule

// File: tb/bus_parity_unit_bench.sv
`timescale 1ns/1ps
module bus_parity_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        perr_resp_en, serr_en;
    logic [1:0]  stat_clr;
    logic [31:0] h_ad, c_ad;
    logic [3:0]  h_cbe, c_cbe;
    logic        h_par_i, h_addr_vld, h_irdy, h_trdy, h_drive;
    logic        c_par_i, c_addr_vld, c_irdy, c_trdy, c_drive;
    logic        h_par_o, h_par_oe, h_perr_n, h_serr_n;
    logic        c_par_o, c_par_oe, c_perr_n;
    logic        stat_parity_err, stat_sys_err;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;
    bit spec_m [2];
    bit pe_m, se_m;

    always #2 clk = ~clk;

    bus_parity_unit u_bus_parity_unit (.*);

    function automatic bit model_par(input logic [31:0] ad, input logic [3:0] cbe);
        return ^{ad, cbe};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        h_addr_vld = 0; h_irdy = 0; h_trdy = 0; h_drive = 0;
        c_addr_vld = 0; c_irdy = 0; c_trdy = 0; c_drive = 0;
    endtask

    task automatic run_phase(input int side, input bit is_addr, input logic [31:0] ad,
                             input logic [3:0] cbe, input bit flip, input bit irdy,
                             input bit trdy, input bit drv);
        bit p, e_data, e_addr, fire;
        p = model_par(ad, cbe);
        e_data = !is_addr && irdy && trdy && !drv && !spec_m[side] && flip;
        e_addr = is_addr && !drv && flip;
        if (is_addr) spec_m[side] = (cbe == 4'b0001);
        @(negedge clk);
        if (side == 0) begin
            h_ad = ad; h_cbe = cbe; h_addr_vld = is_addr; h_irdy = irdy; h_trdy = trdy; h_drive = drv;
        end else begin
            c_ad = ad; c_cbe = cbe; c_addr_vld = is_addr; c_irdy = irdy; c_trdy = trdy; c_drive = drv;
        end
        @(negedge clk);
        if (side == 0) begin
            chk("R2 host par_oe", h_par_oe, drv);
            if (drv) chk("R1 host parity", h_par_o, p);
            h_par_i = p ^ flip;
        end else begin
            chk("R2 card par_oe", c_par_oe, drv);
            if (drv) chk("R1 card parity", c_par_o, p);
            c_par_i = p ^ flip;
        end
        idle_inputs();
        @(negedge clk);
        chk("R3 no early perr", {h_perr_n, c_perr_n, h_serr_n}, 3'b111);
        @(negedge clk);
        fire = e_addr && perr_resp_en && serr_en;
        pe_m = pe_m | e_data | e_addr;
        se_m = se_m | fire;
        if (side == 0) chk("R3 R4 R5 R6 host perr", h_perr_n, !(e_data && perr_resp_en));
        else           chk("R8 card perr", c_perr_n, !(e_data && perr_resp_en));
        chk("R7 R8 serr", h_serr_n, !fire);
        chk("R9 status", {stat_parity_err, stat_sys_err}, {pe_m, se_m});
        @(negedge clk);
        chk("R3 R7 one-clock pulse", {h_perr_n, c_perr_n, h_serr_n}, 3'b111);
    endtask

    task automatic clear_stat(input logic [1:0] v);
        @(negedge clk);
        stat_clr = v;
        @(negedge clk);
        stat_clr = 2'b00;
        if (v[0]) pe_m = 0;
        if (v[1]) se_m = 0;
        chk("R9 clear", {stat_parity_err, stat_sys_err}, {pe_m, se_m});
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed = 32'd1234;
        void'($urandom(seed));
        rst = 1; perr_resp_en = 1; serr_en = 1; stat_clr = 0;
        h_ad = 0; h_cbe = 0; h_par_i = 0; c_ad = 0; c_cbe = 0; c_par_i = 0;
        idle_inputs();
        spec_m[0] = 0; spec_m[1] = 0; pe_m = 0; se_m = 0;
        repeat (3) @(negedge clk);
        chk("R10 reset outputs", {h_perr_n, c_perr_n, h_serr_n, h_par_oe, c_par_oe,
                                  stat_parity_err, stat_sys_err}, 7'b1110000);
        rst = 0;
        @(negedge clk);
        chk("R10 after reset", {h_perr_n, c_perr_n, h_serr_n, h_par_oe, c_par_oe,
                                stat_parity_err, stat_sys_err}, 7'b1110000);

        // R1 R2 generation patterns
        run_phase(0, 0, 32'hFFFF_FFFF, 4'hF, 0, 1, 1, 1);
        run_phase(0, 0, 32'h0000_0001, 4'h0, 0, 1, 1, 1);
        run_phase(1, 1, 32'hA5A5_0F0F, 4'h7, 0, 0, 0, 1);
        // R3 good then bad data
        run_phase(0, 1, 32'h1000_0000, 4'h6, 0, 0, 0, 0);
        run_phase(0, 0, 32'h1234_5678, 4'h0, 0, 1, 1, 0);
        run_phase(0, 0, 32'h1234_5678, 4'h0, 1, 1, 1, 0);
        // R4 half handshakes
        run_phase(0, 0, 32'hDEAD_BEEF, 4'h3, 1, 1, 0, 0);
        run_phase(0, 0, 32'hDEAD_BEEF, 4'h3, 1, 0, 1, 0);
        clear_stat(2'b11);
        // R5 response disabled: no pulse, status still set
        perr_resp_en = 0;
        run_phase(0, 0, 32'h0F0F_0F0F, 4'h1, 1, 1, 1, 0);
        run_phase(0, 1, 32'h2000_0000, 4'h6, 1, 0, 0, 0);
        perr_resp_en = 1;
        clear_stat(2'b01);
        // R6 special cycle exemption then release
        run_phase(0, 1, 32'h0, 4'b0001, 0, 0, 0, 0);
        run_phase(0, 0, 32'h5555_AAAA, 4'h0, 1, 1, 1, 0);
        run_phase(0, 1, 32'h3000_0000, 4'h7, 0, 0, 0, 0);
        run_phase(0, 0, 32'h5555_AAAA, 4'h0, 1, 1, 1, 0);
        // R7 enable combinations
        serr_en = 0;
        run_phase(0, 1, 32'h4000_0000, 4'h6, 1, 0, 0, 0);
        serr_en = 1;
        run_phase(0, 1, 32'h4000_0000, 4'h6, 1, 0, 0, 0);
        // R8 card side forwarding
        run_phase(1, 1, 32'h5000_0000, 4'h6, 1, 0, 0, 0);
        run_phase(1, 0, 32'h0123_4567, 4'hC, 1, 1, 1, 0);
        clear_stat(2'b10);
        clear_stat(2'b01);

        // random mix
        for (int i = 0; i < 400; i++) begin
            int side;
            bit is_addr, drv;
            side    = $urandom % 2;
            is_addr = ($urandom % 4) == 0;
            drv     = ($urandom % 5) == 0;
            perr_resp_en = ($urandom % 6) != 0;
            serr_en      = ($urandom % 4) != 0;
            run_phase(side, is_addr, $urandom,
                      (($urandom % 5) == 0) ? 4'b0001 : 4'($urandom),
                      ($urandom % 3) == 0, ($urandom % 4) != 0, ($urandom % 4) != 0, drv);
            if ((i % 50) == 49) clear_stat(2'($urandom));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule